// File: doc/BRIEF.md
# Line-Interleaved Frame Loader

This block takes pixel words from a 32-bit capture-side bus and fills a line-organized store. The store holds two regions at once: a 64x64 source block and a 144x144 reference search area. Each store row carries one source line in its low slot and one reference line in its high slot. Only the first 64 rows have a source line. The other 80 rows carry reference data only. Both regions arrive in a single pass, one row after another.

A load starts with a pulse on `load_go`. After that, each bus word is taken on a cycle where `wr_strobe` is high. For rows 0 to 63 the word order is 16 source words followed by 36 reference words. For rows 64 to 143 it is 36 reference words only. Once the last reference word of row 143 has been stored, `ready` rises. A controller then reads any row by placing its number on `rd_row`. The source and reference lines of that row appear on the two line outputs one cycle later.

Top module: `line_frame_loader`

## Requirements
- R1: After reset, `ready` is low and no load is in progress.
- R2: Within a line, the k-th accepted word supplies pixels 4k to 4k+3. Pixel 4k+i is taken from bits 8i+7 to 8i of the word, so the least significant byte holds the lowest pixel. Pixel p of a source line appears on `rd_src_line[8p+7:8p]`, and pixel q of a reference line on `rd_ref_line[8q+7:8q]`.
- R3: Rows 0 to 63 each take exactly 52 words: 16 source words, then 36 reference words.
- R4: Rows 64 to 143 each take exactly 36 words, all reference data. The source slot of these rows is never written.
- R5: A word is written only on a cycle where `wr_strobe` is high while a load is in progress. Cycles with the strobe low only stall the load. A strobe while no load is in progress changes no stored data.
- R6: A `load_go` pulse during a load in progress is ignored. The load continues from where it was.
- R7: `ready` rises on the clock edge that accepts the 6208th word of a load, and not earlier. It then stays high until the next accepted `load_go`.
- R8: With the default registered read, the lines of row `rd_row` appear on `rd_src_line` and `rd_ref_line` one cycle after the address is presented.
- R9: A `load_go` received while no load is in progress clears `ready` on the next edge. The next load restarts at row 0, word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_go | input | 1 | Starts a load when no load is in progress |
| wr_strobe | input | 1 | Qualifies `bus_word` as a data word of the load |
| bus_word | input | 32 | Four packed 8-bit pixels |
| ready | output | 1 | All lines of the current load are stored |
| rd_row | input | 8 | Row to read |
| rd_src_line | output | 512 | Source line of the addressed row |
| rd_ref_line | output | 1152 | Reference line of the addressed row |

## Verification
The hardest condition to reach is a start pulse that arrives in the middle of a load while words are still flowing. This case matters because, if the pulse were honoured, the load would silently restart. The stimulus raises `load_go` on the same cycle as a data word inside row 10. It also inserts random stall cycles throughout the load. The restart would then show up in two places: the word count at which `ready` rises, and the contents of rows read afterwards. A second load with a different pixel pattern then shows that every row is rewritten from word 0.

// File: rtl/ld_pkg.sv
package ld_pkg;
   // Default geometry of the loader
   localparam int DEF_PIX_W     = 8;
   localparam int DEF_BUS_W     = 32;
   localparam int DEF_SRC_PIX   = 64;
   localparam int DEF_SRC_LINES = 64;
   localparam int DEF_REF_PIX   = 144;
   localparam int DEF_REF_LINES = 144;

   // Number of bus words needed to carry one line of pixels
   function automatic int words_per_line(input int pixels, input int pix_w, input int bus_w);
      return (pixels * pix_w) / bus_w;
   endfunction
endpackage

// File: rtl/ld_seq.sv
module ld_seq #(
   parameter int SRC_LINES = 64,
   parameter int REF_LINES = 144,
   parameter int SRC_WORDS = 16,
   parameter int REF_WORDS = 36,
   localparam int FULL_WORDS = SRC_WORDS + REF_WORDS,
   localparam int ROW_AW = $clog2(REF_LINES),
   localparam int COL_W  = $clog2(FULL_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic              wr_strobe,
   output logic              busy,
   output logic              ready,
   output logic              wr_en,
   output logic [ROW_AW-1:0] wr_row,
   output logic [COL_W-1:0]  wr_slot
);
   localparam logic [ROW_AW-1:0] LAST_ROW  = ROW_AW'(REF_LINES - 1);
   localparam logic [ROW_AW-1:0] SRC_ROWS  = ROW_AW'(SRC_LINES);
   localparam logic [COL_W-1:0]  LAST_FULL = COL_W'(FULL_WORDS - 1);
   localparam logic [COL_W-1:0]  LAST_REF  = COL_W'(REF_WORDS - 1);
   localparam logic [COL_W-1:0]  SRC_OFS   = COL_W'(SRC_WORDS);

   logic              busy_q, ready_q;
   logic [ROW_AW-1:0] row_q;
   logic [COL_W-1:0]  col_q;
   logic              has_src;
   logic [COL_W-1:0]  last_col;

   assign has_src  = (row_q < SRC_ROWS);
   assign last_col = has_src ? LAST_FULL : LAST_REF;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
      end else if (!busy_q) begin
         if (load_go) begin
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
         end
      end else if (wr_strobe) begin
         if (col_q == last_col) begin
            col_q <= '0;
            if (row_q == LAST_ROW) begin
               busy_q  <= 1'b0;
               ready_q <= 1'b1;
               row_q   <= '0;
            end else begin
               row_q <= row_q + 1'b1;
            end
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign ready   = ready_q;
   assign wr_en   = busy_q && wr_strobe;
   assign wr_row  = row_q;
   assign wr_slot = has_src ? col_q : col_q + SRC_OFS;

   // R6: a start pulse during a load with no word does not move the counters
   p_go_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && load_go && !wr_strobe |=> busy_q && $stable(row_q) && $stable(col_q));

   // R7: ready appears only right after the final word of the last row
   p_ready_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(wr_en) && $past(row_q) == LAST_ROW && $past(col_q) == LAST_REF);

   // R7: ready and a load in progress never coexist
   p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> !busy_q);

   // R3: the word counter stays inside its row length
   p_col_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> col_q <= last_col);
endmodule

// File: rtl/ld_line_mem.sv
module ld_line_mem #(
   parameter int BUS_W     = 32,
   parameter int SRC_BITS  = 512,
   parameter int REF_BITS  = 1152,
   parameter int SRC_LINES = 64,
   parameter int REF_LINES = 144,
   parameter bit READ_REG  = 1'b1,
   localparam int ROW_W     = SRC_BITS + REF_BITS,
   localparam int SRC_WORDS = SRC_BITS / BUS_W,
   localparam int ALL_WORDS = ROW_W / BUS_W,
   localparam int ROW_AW    = $clog2(REF_LINES),
   localparam int COL_W     = $clog2(ALL_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ROW_AW-1:0]   wr_row,
   input  logic [COL_W-1:0]    wr_slot,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic [ROW_AW-1:0]   rd_row,
   output logic [SRC_BITS-1:0] rd_src,
   output logic [REF_BITS-1:0] rd_ref
);
   logic [ROW_W-1:0] rows [REF_LINES];
   logic [ROW_W-1:0] rd_word;
   logic             rd_ok;

   always_ff @(posedge clk) begin
      if (wr_en) rows[wr_row][int'(wr_slot)*BUS_W +: BUS_W] <= wr_data;
   end

   assign rd_ok = (int'(rd_row) < REF_LINES);

   generate
      if (READ_REG) begin : g_rd_reg
         logic [ROW_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_ok) rd_q <= rows[rd_row];
         end
         assign rd_word = rd_q;
      end else begin : g_rd_comb
         assign rd_word = rd_ok ? rows[rd_row] : '0;
      end
   endgenerate

   assign rd_src = rd_word[SRC_BITS-1:0];
   assign rd_ref = rd_word[ROW_W-1:SRC_BITS];

   // R4: rows past the source block never touch the source slot
   p_src_slot_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && int'(wr_row) >= SRC_LINES |-> int'(wr_slot) >= SRC_WORDS);

   // R3: every write lands inside the row
   p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(wr_slot) < ALL_WORDS && int'(wr_row) < REF_LINES);
endmodule

// File: rtl/line_frame_loader.sv
module line_frame_loader #(
   parameter int PIX_W     = ld_pkg::DEF_PIX_W,
   parameter int BUS_W     = ld_pkg::DEF_BUS_W,
   parameter int SRC_PIX   = ld_pkg::DEF_SRC_PIX,
   parameter int SRC_LINES = ld_pkg::DEF_SRC_LINES,
   parameter int REF_PIX   = ld_pkg::DEF_REF_PIX,
   parameter int REF_LINES = ld_pkg::DEF_REF_LINES,
   parameter bit READ_REG  = 1'b1,
   localparam int SRC_BITS  = SRC_PIX * PIX_W,
   localparam int REF_BITS  = REF_PIX * PIX_W,
   localparam int SRC_WORDS = ld_pkg::words_per_line(SRC_PIX, PIX_W, BUS_W),
   localparam int REF_WORDS = ld_pkg::words_per_line(REF_PIX, PIX_W, BUS_W),
   localparam int ROW_AW    = $clog2(REF_LINES),
   localparam int COL_W     = $clog2(SRC_WORDS + REF_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_go,
   input  logic                wr_strobe,
   input  logic [BUS_W-1:0]    bus_word,
   output logic                ready,
   input  logic [ROW_AW-1:0]   rd_row,
   output logic [SRC_BITS-1:0] rd_src_line,
   output logic [REF_BITS-1:0] rd_ref_line
);
   // Elaboration checks on the geometry
   if (BUS_W % PIX_W != 0) begin : g_bad_lane
      $error("bus width must hold a whole number of pixels");
   end
   if (SRC_BITS % BUS_W != 0 || REF_BITS % BUS_W != 0) begin : g_bad_line
      $error("each line must fill a whole number of bus words");
   end
   if (SRC_LINES > REF_LINES) begin : g_bad_rows
      $error("source block must not be taller than the reference area");
   end

   logic              busy, wr_en;
   logic [ROW_AW-1:0] wr_row;
   logic [COL_W-1:0]  wr_slot;

   ld_seq #(
      .SRC_LINES(SRC_LINES), .REF_LINES(REF_LINES),
      .SRC_WORDS(SRC_WORDS), .REF_WORDS(REF_WORDS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .wr_strobe(wr_strobe),
      .busy(busy), .ready(ready), .wr_en(wr_en), .wr_row(wr_row), .wr_slot(wr_slot)
   );

   ld_line_mem #(
      .BUS_W(BUS_W), .SRC_BITS(SRC_BITS), .REF_BITS(REF_BITS),
      .SRC_LINES(SRC_LINES), .REF_LINES(REF_LINES), .READ_REG(READ_REG)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_slot(wr_slot),
      .wr_data(bus_word), .rd_row(rd_row), .rd_src(rd_src_line), .rd_ref(rd_ref_line)
   );

   // R5: no store write happens once the frame is declared complete
   p_no_write_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !ready);

   // R5: writes only while a load is under way
   p_write_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy && wr_strobe);
endmodule

// File: tb/tb_line_frame_loader.sv
module tb_line_frame_loader;
   localparam int SRC_PIX = 64, REF_PIX = 144, SRC_LINES = 64, REF_LINES = 144;
   localparam int SRC_WORDS = 16, REF_WORDS = 36, TOTAL_WORDS = 6208;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_go = 1'b0;
   logic              wr_strobe = 1'b0;
   logic [31:0]       bus_word = '0;
   logic              ready;
   logic [7:0]        rd_row = '0;
   logic [SRC_PIX*8-1:0] rd_src_line;
   logic [REF_PIX*8-1:0] rd_ref_line;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int words_sent = 0;

   line_frame_loader dut (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .wr_strobe(wr_strobe),
      .bus_word(bus_word), .ready(ready), .rd_row(rd_row),
      .rd_src_line(rd_src_line), .rd_ref_line(rd_ref_line)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [7:0] px(input int key, input int line, input int p, input int is_ref);
      int v;
      v = key * 37 + line * 11 + p * 5 + is_ref * 91 + ((line * p) % 7) * 19;
      return v[7:0];
   endfunction

   function automatic logic [31:0] pack_word(input int key, input int line, input int k, input int is_ref);
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = px(key, line, 4*k + b, is_ref);
      return w;
   endfunction

   function automatic logic [SRC_PIX*8-1:0] exp_src(input int key, input int line);
      logic [SRC_PIX*8-1:0] l;
      for (int p = 0; p < SRC_PIX; p++) l[8*p +: 8] = px(key, line, p, 0);
      return l;
   endfunction

   function automatic logic [REF_PIX*8-1:0] exp_ref(input int key, input int line);
      logic [REF_PIX*8-1:0] l;
      for (int p = 0; p < REF_PIX; p++) l[8*p +: 8] = px(key, line, p, 1);
      return l;
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
      end
   endtask

   // R8 read path: address at a falling edge, data checked at the next falling edge
   task automatic check_row(input string tag, input int row, input int key, input bit src_ok);
      @(negedge clk);
      rd_row = 8'(row);
      @(negedge clk);
      if (src_ok) begin
         checks++;
         if (rd_src_line !== exp_src(key, row)) begin
            fails++;
            $display("FAIL %s R2 R8 source row %0d: actual %h expected %h",
                     tag, row, rd_src_line, exp_src(key, row));
         end
      end
      checks++;
      if (rd_ref_line !== exp_ref(key, row)) begin
         fails++;
         $display("FAIL %s R2 R8 reference row %0d: actual %h expected %h",
                  tag, row, rd_ref_line, exp_ref(key, row));
      end
   endtask

   task automatic put_word(input logic [31:0] w, input bit gaps, input bit go_too);
      if (gaps && ($urandom % 4) == 0) begin
         wr_strobe = 1'b0;
         bus_word  = $urandom;
         @(negedge clk);
      end
      wr_strobe = 1'b1;
      bus_word  = w;
      load_go   = go_too;
      if (words_sent == TOTAL_WORDS - 1)
         check_bit("R7 ready before last word", ready, 1'b0);
      @(negedge clk);
      load_go = 1'b0;
      words_sent++;
      if (go_too) check_bit("R6 start during load keeps ready low", ready, 1'b0);
   endtask

   task automatic load_frame(input int key, input bit gaps, input bit inject);
      words_sent = 0;
      @(negedge clk);
      load_go = 1'b1;
      @(negedge clk);
      load_go = 1'b0;
      check_bit("R9 ready cleared by start", ready, 1'b0);
      for (int r = 0; r < REF_LINES; r++) begin
         if (r < SRC_LINES)
            for (int k = 0; k < SRC_WORDS; k++)
               put_word(pack_word(key, r, k, 0), gaps, inject && r == 10 && k == 3);
         for (int k = 0; k < REF_WORDS; k++)
            put_word(pack_word(key, r, k, 1), gaps, 1'b0);
      end
      wr_strobe = 1'b0;
      check_bit("R7 ready after final word", ready, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_bit("R1 ready low in reset", ready, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 ready low after reset", ready, 1'b0);

      // R5: strobes with no load in progress must not start anything
      wr_strobe = 1'b1;
      bus_word  = 32'hDEAD_BEEF;
      repeat (5) @(negedge clk);
      wr_strobe = 1'b0;
      check_bit("R5 strobe without load leaves ready low", ready, 1'b0);

      // First load: random stalls and a start pulse injected mid-load (R6)
      load_frame(3, 1'b1, 1'b1);
      check_row("R3 first source row", 0, 3, 1'b1);
      check_row("R3 last source row", 63, 3, 1'b1);
      check_row("R4 first reference-only row", 64, 3, 1'b0);
      check_row("R4 last row", 143, 3, 1'b0);
      check_row("R6 row loaded around the start pulse", 10, 3, 1'b1);
      for (int i = 0; i < 12; i++) begin
         int r;
         r = $urandom % REF_LINES;
         check_row("R2 random row", r, 3, r < SRC_LINES);
      end

      // R5: strobes after completion change nothing
      wr_strobe = 1'b1;
      for (int i = 0; i < 10; i++) begin
         bus_word = $urandom;
         @(negedge clk);
      end
      wr_strobe = 1'b0;
      check_bit("R5 ready held under idle strobes", ready, 1'b1);
      check_row("R5 row 0 unchanged", 0, 3, 1'b1);
      check_row("R5 row 143 unchanged", 143, 3, 1'b0);

      // Second load: new pattern, back-to-back words (R9 restart from row 0)
      load_frame(41, 1'b0, 1'b0);
      check_row("R9 row 0 rewritten", 0, 41, 1'b1);
      check_row("R9 row 100 rewritten", 100, 41, 1'b0);
      for (int i = 0; i < 8; i++) begin
         int r;
         r = $urandom % REF_LINES;
         check_row("R2 random row second load", r, 41, r < SRC_LINES);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule